// File: doc/BRIEF.md
# Transmit Source Address Inserter

This block sits on the outgoing byte stream between the application and the MAC framing stage. For each frame it can put a station address into the source address field, either by splicing six new bytes in after the destination address or by overwriting the six bytes that already sit there. All other bytes pass through untouched. Both sides are byte streams with valid/ready handshaking and start-of-frame and end-of-frame markers.

A 3-bit mode input controls the block. Bit 2 picks one of two 48-bit station address inputs. Bits [1:0] pick the operation: 2'b10 inserts and 2'b11 replaces. The block copies the mode and the chosen address on the first byte of a frame. A change made while a frame is in flight therefore takes effect only from the next frame.

Top module: `tx_srcaddr_ins`

## Requirements
- R1: After reset, with no input offered, out_valid_o is low and in_ready_o follows out_ready_i.
- R2: Mode code 2 inserts the six octets of addr0_i after input byte 5, so the frame grows by six bytes.
- R3: Mode code 6 inserts the six octets of addr1_i after input byte 5.
- R4: Mode code 3 overwrites input bytes 6 to 11 with addr0_i. Bytes are consumed one for one and frame length is unchanged, with no input stall.
- R5: Mode code 7 overwrites input bytes 6 to 11 with addr1_i.
- R6: Mode codes 0, 1, 4 and 5 pass the frame through unmodified.
- R7: The mode and both address inputs are sampled on the frame's first byte. A change made later in that frame affects only the next frame.
- R8: Address octets are emitted least significant first, with octet 0 taken from bits [7:0].
- R9: During insertion, in_ready_o stays low for exactly six accepted output cycles. The inserted bytes carry neither start-of-frame nor end-of-frame. Under output backpressure the byte on offer holds steady.
- R10: In replace mode, a frame shorter than 12 bytes has only the bytes it has overwritten, and its end-of-frame stays on its last byte.
- R11: In insert mode, a frame of 6 bytes or fewer passes unchanged with no insertion and no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operation code: bit 2 selects the address, bits [1:0] select insert (10) or replace (11) |
| addr0_i | input | 48 | Station address 0, octet 0 in bits [7:0] |
| addr1_i | input | 48 | Station address 1, octet 0 in bits [7:0] |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_data_i | input | 8 | Input byte |
| in_sof_i | input | 1 | Input byte is first of frame |
| in_eof_i | input | 1 | Input byte is last of frame |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | Output byte is first of frame |
| out_eof_o | output | 1 | Output byte is last of frame |

## Verification
The bench goes after the edges of the address window. It checks byte 5 against byte 6, and byte 11 against byte 12. A design that is off by one there shifts the address or corrupts a payload byte. It drives short frames in both modes: a replace frame that ends inside the window, and insert frames of six bytes or fewer. A design that mishandles these would drop end-of-frame or tack an address onto a frame that has no room for it. It changes the mode and both addresses in the middle of a frame. A design that samples them live would switch operation half way through that frame. Random output backpressure during insertion exposes a sequencer that advances without a handshake, which would skip or repeat address octets.

// File: rtl/srcaddr_pkg.sv
package srcaddr_pkg;
  typedef enum logic [1:0] {
    ACT_PASS    = 2'd0,
    ACT_INSERT  = 2'd1,
    ACT_REPLACE = 2'd2
  } sa_act_e;

  localparam logic [1:0] OP_INSERT  = 2'b10;
  localparam logic [1:0] OP_REPLACE = 2'b11;

  function automatic sa_act_e decode_op(input logic [2:0] mode);
    case (mode[1:0])
      OP_INSERT:  return ACT_INSERT;
      OP_REPLACE: return ACT_REPLACE;
      default:    return ACT_PASS;
    endcase
  endfunction
endpackage

// File: rtl/srcaddr_shadow.sv
module srcaddr_shadow
  import srcaddr_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic              start_i,    // first byte on offer
  input  logic              start_take_i,
  output sa_act_e           act_o,
  output logic [ADDR_W-1:0] addr_o
);
  sa_act_e           act_q, live_act;
  logic [ADDR_W-1:0] addr_q, live_addr;

  assign live_act  = decode_op(mode_i);
  assign live_addr = mode_i[2] ? addr1_i : addr0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= ACT_PASS;
      addr_q <= '0;
    end else if (start_take_i) begin
      act_q  <= live_act;
      addr_q <= live_addr;
    end
  end

  assign act_o  = start_i ? live_act  : act_q;
  assign addr_o = start_i ? live_addr : addr_q;

  AST_SHADOW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_take_i |=> ($stable(act_q) && $stable(addr_q))); // R7
endmodule

// File: rtl/srcaddr_pos.sv
module srcaddr_pos #(
  parameter int IDX_W = 4,
  parameter int SAT   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  assign idx_o = sof_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               idx_q <= '0;
    else if (take_i) begin
      if (eof_i)               idx_q <= '0;
      else if (idx_o == IDX_W'(SAT)) idx_q <= IDX_W'(SAT);
      else                     idx_q <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/srcaddr_ins_seq.sv
module srcaddr_ins_seq #(
  parameter int AB    = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(AB - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt_o    <= '0;
    end else if (active_o && adv_i) begin
      if (cnt_o == LAST) active_o <= 1'b0;
      else               cnt_o    <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tx_srcaddr_ins.sv
module tx_srcaddr_ins
  import srcaddr_pkg::*;
#(
  parameter int DA_BYTES   = 6,
  parameter int ADDR_BYTES = 6,
  parameter int DATA_W     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   mode_i,
  input  logic [ADDR_BYTES*DATA_W-1:0] addr0_i,
  input  logic [ADDR_BYTES*DATA_W-1:0] addr1_i,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic [DATA_W-1:0]            in_data_i,
  input  logic                         in_sof_i,
  input  logic                         in_eof_i,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [DATA_W-1:0]            out_data_o,
  output logic                         out_sof_o,
  output logic                         out_eof_o
);
  localparam int ADDR_W = ADDR_BYTES * DATA_W;
  localparam int SAT    = DA_BYTES + ADDR_BYTES;
  localparam int IDX_W  = $clog2(SAT + 1);
  localparam int CNT_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic              ins_active, take_in, out_fire, frame_start, sof_take, start_ins;
  logic [CNT_W-1:0]  ins_cnt;
  logic [IDX_W-1:0]  cur_idx;
  sa_act_e           eff_act;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] addr_b [ADDR_BYTES];
  logic [DATA_W-1:0] ins_byte, rep_byte;
  logic              rep_win;

  assign in_ready_o  = out_ready_i && !ins_active;
  assign out_valid_o = ins_active || in_valid_i;
  assign take_in     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign frame_start = in_valid_i && in_sof_i && !ins_active;
  assign sof_take    = take_in && in_sof_i;

  srcaddr_shadow #(.ADDR_W(ADDR_W)) u_shadow (
    .clk_i, .rst_ni, .mode_i, .addr0_i, .addr1_i,
    .start_i(frame_start), .start_take_i(sof_take),
    .act_o(eff_act), .addr_o(eff_addr)
  );

  srcaddr_pos #(.IDX_W(IDX_W), .SAT(SAT)) u_pos (
    .clk_i, .rst_ni, .take_i(take_in), .sof_i(in_sof_i), .eof_i(in_eof_i),
    .idx_o(cur_idx)
  );

  // insertion only when the frame continues past the destination address
  assign start_ins = take_in && !in_eof_i && (eff_act == ACT_INSERT)
                     && (cur_idx == IDX_W'(DA_BYTES - 1));

  srcaddr_ins_seq #(.AB(ADDR_BYTES), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start_ins), .adv_i(out_fire),
    .active_o(ins_active), .cnt_o(ins_cnt)
  );

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_octet
    assign addr_b[g] = eff_addr[g*DATA_W +: DATA_W];
  end

  always_comb begin
    ins_byte = '0;
    rep_byte = '0;
    rep_win  = 1'b0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (ins_cnt == CNT_W'(k)) ins_byte = addr_b[k];
      if (cur_idx == IDX_W'(DA_BYTES + k)) begin
        rep_win  = (eff_act == ACT_REPLACE);
        rep_byte = addr_b[k];
      end
    end
  end

  always_comb begin
    if (ins_active) begin
      out_data_o = ins_byte;
      out_sof_o  = 1'b0;
      out_eof_o  = 1'b0;
    end else begin
      out_data_o = rep_win ? rep_byte : in_data_i;
      out_sof_o  = in_sof_i;
      out_eof_o  = in_eof_i;
    end
  end

  AST_INS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_active && !out_ready_i) |=> (ins_active && $stable(out_data_o))); // R9
  AST_INS_SIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ins_active) |-> ($past(ins_cnt) == CNT_W'(ADDR_BYTES - 1))); // R2
  AST_RESERVED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_active && eff_act == ACT_PASS && out_valid_o) |-> (out_data_o == in_data_i)); // R6
  AST_REPLACE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_act == ACT_REPLACE) |-> !ins_active); // R4
endmodule

// File: tb/tx_srcaddr_ins_tb.sv
`timescale 1ns/1ps
module tx_srcaddr_ins_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  mode_i;
  logic [47:0] addr0_i, addr1_i;
  logic        in_valid_i, in_ready_o, in_sof_i, in_eof_i;
  logic [7:0]  in_data_i;
  logic        out_valid_o, out_ready_i, out_sof_o, out_eof_o;
  logic [7:0]  out_data_o;

  always #2.5 clk_i = ~clk_i;

  tx_srcaddr_ins u_dut (.*);

  logic [9:0]  exp_q[$];
  string       tag_q[$];
  int          checks = 0, errors = 0, stalls;
  bit          rand_rdy = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [9:0]  e;
  string       t;

  function automatic logic [7:0] pay(int seed, int i);
    return 8'(seed * 37 + i * 11 + 5);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready_i = rand_rdy ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor: pops expected bytes in output order
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected byte actual %h expected none",
                 {out_sof_o, out_eof_o, out_data_o});
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_sof_o, out_eof_o, out_data_o} !== e) begin
          errors++;
          $display("FAIL %s sof/eof/data actual %h expected %h", t,
                   {out_sof_o, out_eof_o, out_data_o}, e);
        end
      end
    end
  end

  task automatic send_frame(int len, logic [2:0] mode, int seed, string tag,
                            int chg_at, logic [2:0] chg_mode);
    logic [47:0] a;
    logic [7:0]  d;
    bit          ins, rep, acc;
    mode_i = mode;
    ins = (mode[1:0] == 2'b10);
    rep = (mode[1:0] == 2'b11);
    a   = mode[2] ? addr1_i : addr0_i;
    for (int i = 0; i < len; i++) begin
      d = pay(seed, i);
      if (rep && i >= 6 && i < 12) d = a[8*(i-6) +: 8];
      exp_q.push_back({1'(i == 0), 1'(i == len - 1), d});
      tag_q.push_back(tag);
      if (ins && i == 5 && len > 6)
        for (int k = 0; k < 6; k++) begin
          exp_q.push_back({2'b00, a[8*k +: 8]});
          tag_q.push_back(tag);
        end
    end
    stalls = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk_i); #1;
      if (i == chg_at) begin
        mode_i  = chg_mode;
        addr0_i = ~addr0_i;
        addr1_i = addr1_i ^ 48'h0F0F_0F0F_0F0F;
      end
      in_valid_i = 1'b1;
      in_data_i  = pay(seed, i);
      in_sof_i   = (i == 0);
      in_eof_i   = (i == len - 1);
      acc = 0;
      while (!acc) begin
        @(negedge clk_i);
        acc = in_ready_o;
        if (!acc) begin
          if (out_ready_i) stalls++;
          @(posedge clk_i); #1;
        end
      end
    end
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    in_sof_i   = 1'b0;
    in_eof_i   = 1'b0;
  endtask

  task automatic drain(string tag);
    for (int c = 0; c < 2000 && exp_q.size() != 0; c++) @(posedge clk_i);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0; mode_i = 0; in_valid_i = 0; in_sof_i = 0; in_eof_i = 0;
    in_data_i = 0; out_ready_i = 1;
    addr0_i = 48'h6655_4433_2211;
    addr1_i = 48'hCCBB_AA99_8877;
    repeat (5) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    check(out_valid_o == 0, "R1 out_valid", out_valid_o, 0);
    check(in_ready_o == 1, "R1 in_ready", in_ready_o, 1);

    send_frame(20, 3'd2, 1, "R2 R8", -1, 3'd0);
    check(stalls == 6, "R9 insert stall count", stalls, 6);
    send_frame(20, 3'd3, 2, "R4 R8", -1, 3'd0);
    check(stalls == 0, "R4 replace stall count", stalls, 0);
    send_frame(15, 3'd6, 3, "R3", -1, 3'd0);
    send_frame(16, 3'd7, 4, "R5", -1, 3'd0);
    send_frame(14, 3'd0, 5, "R6", -1, 3'd0);
    send_frame(14, 3'd1, 6, "R6", -1, 3'd0);
    send_frame(14, 3'd4, 7, "R6", -1, 3'd0);
    send_frame(14, 3'd5, 8, "R6", -1, 3'd0);
    check(stalls == 0, "R6 reserved stall count", stalls, 0);
    send_frame(9, 3'd3, 9, "R10", -1, 3'd0);
    send_frame(12, 3'd7, 10, "R10", -1, 3'd0);
    send_frame(6, 3'd2, 11, "R11", -1, 3'd0);
    check(stalls == 0, "R11 six-byte stall count", stalls, 0);
    send_frame(7, 3'd6, 12, "R11", -1, 3'd0);
    check(stalls == 6, "R11 seven-byte stall count", stalls, 6);
    send_frame(1, 3'd2, 13, "R11", -1, 3'd0);
    send_frame(20, 3'd3, 14, "R7", 3, 3'd6);
    check(stalls == 0, "R7 mid-frame change stall count", stalls, 0);
    send_frame(20, 3'd6, 15, "R7", -1, 3'd0);
    check(stalls == 6, "R7 next frame stall count", stalls, 6);
    drain("R7 drain");

    rand_rdy = 1;
    for (int f = 0; f < 12; f++)
      send_frame(8 + f * 3, (f % 2) ? 3'd7 : 3'd2, 20 + f, "R9", -1, 3'd0);
    send_frame(10, 3'd3, 40, "R10", -1, 3'd0);
    send_frame(30, 3'd6, 41, "R9", 8, 3'd3);
    drain("R9 drain");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule